// File: doc/BRIEF.md
# QUBO Energy Evaluator

This block scores one candidate assignment of binary decision variables against a quadratic objective. A search engine around it proposes vectors, and the block returns the objective value for each; a smaller value is a better candidate. Variable i takes the value of candidate bit i, either 0 or 1. The objective adds a signed coefficient for every pair of set variables (i, j) with i < j, and adds the diagonal coefficient of variable i when that variable alone is set. Every product of binary values reduces to an AND, so the datapath gates coefficients instead of multiplying them.

Coefficients are written one at a time through a port that takes a row index, a column index and a signed value. Only the upper triangle is held in storage. A write to the lower triangle is folded onto its mirror cell. The caller pulses `start` with a candidate vector. The block then walks the coefficient rows one per clock and raises `done` with the signed energy. The result stays on the outputs until the next accepted start. The dimension and the coefficient width are parameters, and the accumulator is sized so that no sum can overflow.

Top module: `qubo_energy_eval`

## Requirements
- R1: After reset, `busy`, `done`, `wr_reject` and `energy` are 0 and every stored coefficient is 0, so any candidate evaluates to 0.
- R2: For candidate bits x (bit i is variable i), `energy` equals the sum of beta(i,i) over set bits i plus the sum of beta(i,j) over pairs i < j where both bits are set. Coefficients are two's complement, `COEF_W` bits wide.
- R3: A write with `wr_row` > `wr_col` stores the value into cell (`wr_col`, `wr_row`), so it has the same effect as a write with the indices swapped.
- R4: When `start` is sampled with `busy` low, the candidate is captured and `busy` is high for exactly `N_MAX` cycles. `done` rises on the rising edge that ends `busy`, which is the (`N_MAX`+1)-th edge counting the edge that sampled `start`.
- R5: `done` and `energy` keep their values until the next accepted start. `done` falls on that start edge.
- R6: `start` while `busy` is high is ignored: the running evaluation and its result are unaffected.
- R7: A write while `busy` is high is rejected. The stored coefficient is unchanged, and `wr_reject` is high for exactly the one cycle after the write. `wr_reject` is low after any cycle without such a write.
- R8: A write in the same cycle as an accepted start is stored and takes part in that evaluation.
- R9: A later accepted write to the same cell replaces the earlier value.
- R10: The energy is exact at the extremes: all coefficients at the largest positive value, or at the most negative value, with every bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Coefficient write request |
| wr_row | input | IDX_W | Row index of the coefficient |
| wr_col | input | IDX_W | Column index of the coefficient |
| wr_coef | input | COEF_W | Signed coefficient value |
| wr_reject | output | 1 | High for one cycle after a write refused because busy |
| start | input | 1 | Begin an evaluation of `cand` |
| cand | input | N_MAX | Candidate vector, bit i is variable i |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | Energy valid, held until the next start |
| energy | output | ACC_W | Signed objective value |

## Verification
Two pairs of functions can land on the same edge: a coefficient write with the start of an evaluation, and a write or a second start during a running evaluation. The bench provokes the first by driving a write and a start in the same cycle to a diagonal cell whose variable is set. It judges the outcome by whether the new value appears in that evaluation's energy. It provokes the second by issuing a write and a start with a different candidate mid-evaluation. It then checks the reject pulse, that the energy belongs to the first candidate, and, by a later evaluation, that the coefficient kept its old value.

// File: rtl/qubo_eval_pkg.sv
// Package: shared sizing helpers for the QUBO energy evaluator.
// Assumes dimension n >= 2 and coefficient width >= 2.
package qubo_eval_pkg;

    // Number of upper-triangle cells, diagonal included.
    function automatic int tri_cells(input int n);
        return (n * (n + 1)) / 2;
    endfunction

    // Accumulator width: coefficient width plus growth for every cell plus one guard bit.
    function automatic int acc_width(input int n, input int coef_w);
        return coef_w + $clog2(tri_cells(n)) + 1;
    endfunction

    // Index width for n rows or columns.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/qubo_coef_bank.sv
// Module: qubo_coef_bank
// Holds the upper-triangle coefficient cells and presents one full row for reading.
// A write to (r, c) with r > c is folded onto (c, r). Lower-triangle positions
// of the read row are constant zero. Assumes the caller has already decided
// whether the write is allowed (wr_accept).
module qubo_coef_bank #(
    parameter int N_MAX  = 8,
    parameter int COEF_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_accept,
    input  logic [IDX_W-1:0]                wr_row,
    input  logic [IDX_W-1:0]                wr_col,
    input  logic [COEF_W-1:0]               wr_coef,
    input  logic [IDX_W-1:0]                rd_row,
    output logic [N_MAX-1:0][COEF_W-1:0]    rd_data
);

    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;
    logic [N_MAX-1:0][N_MAX-1:0][COEF_W-1:0] grid;

    // Fold the index pair onto the upper triangle.
    always_comb begin
        if (wr_row > wr_col) begin
            lo_idx = wr_col;
            hi_idx = wr_row;
        end else begin
            lo_idx = wr_row;
            hi_idx = wr_col;
        end
    end

    for (genvar r = 0; r < N_MAX; r++) begin : g_row
        for (genvar c = 0; c < N_MAX; c++) begin : g_col
            if (c >= r) begin : g_cell
                localparam logic [IDX_W-1:0] ROW_ID = IDX_W'(r);
                localparam logic [IDX_W-1:0] COL_ID = IDX_W'(c);
                logic [COEF_W-1:0] cell_q;

                // Store one coefficient; cleared by reset.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        cell_q <= '0;
                    end else if (wr_accept && (lo_idx == ROW_ID) && (hi_idx == COL_ID)) begin
                        cell_q <= wr_coef;
                    end
                end

                assign grid[r][c] = cell_q;
            end else begin : g_empty
                assign grid[r][c] = '0;
            end
        end
    end

    // Row read mux.
    assign rd_data = grid[rd_row];

endmodule

// File: rtl/qubo_row_adder.sv
// Module: qubo_row_adder
// Sums the gated coefficients of one row: cell (row, c) counts when c >= row
// and both candidate bits row and c are set (the diagonal needs only bit row).
// Purely combinational; result is sign-extended to the accumulator width.
module qubo_row_adder #(
    parameter int N_MAX  = 8,
    parameter int COEF_W = 8,
    parameter int IDX_W  = 3,
    parameter int ACC_W  = 15
) (
    input  logic [IDX_W-1:0]             row,
    input  logic [N_MAX-1:0]             cand_bits,
    input  logic [N_MAX-1:0][COEF_W-1:0] row_data,
    output logic signed [ACC_W-1:0]      row_sum
);

    logic row_live;

    // The whole row contributes nothing unless its own variable is set.
    assign row_live = cand_bits[row];

    // Bit-gated sum of the row's upper-triangle cells.
    always_comb begin
        logic signed [COEF_W-1:0] term;
        row_sum = '0;
        for (int c = 0; c < N_MAX; c++) begin
            term = row_data[c];
            if (row_live && cand_bits[c] && (c >= int'(row))) begin
                row_sum = row_sum + ACC_W'(term);
            end
        end
    end

endmodule

// File: rtl/qubo_eval_seq.sv
// Module: qubo_eval_seq
// Sequences one evaluation: captures the candidate on an accepted start, steps
// the row index once per cycle over all N_MAX rows, accumulates the row sums and
// publishes the energy with done on the last row. Starts while busy are ignored.
module qubo_eval_seq #(
    parameter int N_MAX = 8,
    parameter int IDX_W = 3,
    parameter int ACC_W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_MAX-1:0]        cand,
    input  logic signed [ACC_W-1:0] row_sum,
    output logic                    busy,
    output logic                    done,
    output logic signed [ACC_W-1:0] energy,
    output logic [IDX_W-1:0]        row,
    output logic [N_MAX-1:0]        cand_bits
);

    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(N_MAX - 1);

    logic signed [ACC_W-1:0] acc_q;

    // Control, row stepping and accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            energy    <= '0;
            row       <= '0;
            cand_bits <= '0;
            acc_q     <= '0;
        end else if (start && !busy) begin
            busy      <= 1'b1;
            done      <= 1'b0;
            row       <= '0;
            acc_q     <= '0;
            cand_bits <= cand;
        end else if (busy) begin
            if (row == LAST_ROW) begin
                busy   <= 1'b0;
                done   <= 1'b1;
                energy <= acc_q + row_sum;
            end else begin
                row   <= row + 1'b1;
                acc_q <= acc_q + row_sum;
            end
        end
    end

endmodule

// File: rtl/qubo_energy_eval.sv
// Module: qubo_energy_eval (top)
// Evaluates a quadratic binary objective for one candidate vector. Coefficients
// are loaded through a single write port; writes while an evaluation runs are
// refused and flagged for one cycle. Assumes N_MAX >= 2.
module qubo_energy_eval #(
    parameter int N_MAX  = 8,
    parameter int COEF_W = 8,
    parameter int IDX_W  = qubo_eval_pkg::idx_width(N_MAX),
    parameter int ACC_W  = qubo_eval_pkg::acc_width(N_MAX, COEF_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_row,
    input  logic [IDX_W-1:0]        wr_col,
    input  logic [COEF_W-1:0]       wr_coef,
    output logic                    wr_reject,
    input  logic                    start,
    input  logic [N_MAX-1:0]        cand,
    output logic                    busy,
    output logic                    done,
    output logic signed [ACC_W-1:0] energy
);

    logic                            wr_accept;
    logic [IDX_W-1:0]                cur_row;
    logic [N_MAX-1:0]                cand_bits;
    logic [N_MAX-1:0][COEF_W-1:0]    row_data;
    logic signed [ACC_W-1:0]         row_sum;

    // Writes are taken only while no evaluation is running.
    assign wr_accept = wr_en && !busy;

    // Flag a refused write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_reject <= 1'b0;
        end else begin
            wr_reject <= wr_en && busy;
        end
    end

    qubo_coef_bank #(
        .N_MAX (N_MAX),
        .COEF_W(COEF_W),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_accept(wr_accept),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_coef  (wr_coef),
        .rd_row   (cur_row),
        .rd_data  (row_data)
    );

    qubo_row_adder #(
        .N_MAX (N_MAX),
        .COEF_W(COEF_W),
        .IDX_W (IDX_W),
        .ACC_W (ACC_W)
    ) u_adder (
        .row      (cur_row),
        .cand_bits(cand_bits),
        .row_data (row_data),
        .row_sum  (row_sum)
    );

    qubo_eval_seq #(
        .N_MAX(N_MAX),
        .IDX_W(IDX_W),
        .ACC_W(ACC_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cand     (cand),
        .row_sum  (row_sum),
        .busy     (busy),
        .done     (done),
        .energy   (energy),
        .row      (cur_row),
        .cand_bits(cand_bits)
    );

endmodule

// File: rtl/qubo_energy_eval_chk.sv
// Module: qubo_energy_eval_chk
// Protocol checks on the evaluator's ports, attached with bind.
module qubo_energy_eval_chk #(
    parameter int N_MAX  = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = qubo_eval_pkg::acc_width(N_MAX, COEF_W)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    wr_reject,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic signed [ACC_W-1:0] energy
);

    int busy_cycles;

    // Count cycles spent busy, to measure the evaluation window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_cycles <= 0;
        end else begin
            busy_cycles <= busy_cycles + 1;
        end
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done)); // R4
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cycles == N_MAX - 1) |=> (!busy && done)); // R4
    AST_BUSY_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cycles < N_MAX - 1) |=> busy); // R4
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(energy))); // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && busy_cycles < N_MAX - 1) |=> busy); // R6
    AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> wr_reject); // R7
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && busy) |=> !wr_reject); // R7

endmodule

bind qubo_energy_eval qubo_energy_eval_chk #(
    .N_MAX (N_MAX),
    .COEF_W(COEF_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_reject(wr_reject),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .energy   (energy)
);

// File: tb/tb_qubo_energy_eval.sv
// Bench for qubo_energy_eval: directed corners plus seeded random stimulus,
// compared with a reference model of the coefficient triangle.
module tb_qubo_energy_eval;

    localparam int N  = 8;
    localparam int CW = 8;
    localparam int IW = 3;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_row = '0;
    logic [IW-1:0] wr_col = '0;
    logic [CW-1:0] wr_coef = '0;
    logic          wr_reject;
    logic          start = 1'b0;
    logic [N-1:0]  cand = '0;
    logic          busy;
    logic          done;
    logic signed [AW-1:0] energy;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int mdl [N][N];

    always #5 clk = ~clk;

    qubo_energy_eval #(.N_MAX(N), .COEF_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
        .wr_coef(wr_coef), .wr_reject(wr_reject), .start(start), .cand(cand),
        .busy(busy), .done(done), .energy(energy)
    );

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            report();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_energy(input logic [N-1:0] x);
        int s = 0;
        for (int i = 0; i < N; i++)
            for (int j = i; j < N; j++)
                if (x[i] && x[j]) s += mdl[i][j];
        return s;
    endfunction

    // One write cycle; exp_rej says whether the bench expects a refusal.
    task automatic write_coef(input int r, input int c, input int v, input bit exp_rej);
        @(negedge clk);
        wr_en = 1'b1; wr_row = IW'(r); wr_col = IW'(c); wr_coef = CW'(v);
        @(negedge clk);
        wr_en = 1'b0;
        if (!exp_rej) begin
            if (r > c) mdl[c][r] = v; else mdl[r][c] = v;
        end
        check(wr_reject == exp_rej, "R7 reject flag", int'(wr_reject), int'(exp_rej));
    endtask

    // Full evaluation with cycle-exact done timing.
    task automatic eval_chk(input logic [N-1:0] x, input string req);
        int got;
        @(negedge clk);
        start = 1'b1; cand = x;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R4 busy after start", int'(busy), 1);
        repeat (N - 1) @(negedge clk);
        check(busy && !done, "R4 not done early", int'(done), 0);
        @(negedge clk);
        check(done && !busy, "R4 done on time", int'(done), 1);
        got = int'(energy);
        check(got == ref_energy(x), req, got, ref_energy(x));
    endtask

    task automatic wait_done();
        for (int k = 0; k < 4 * N && !done; k++) @(negedge clk);
    endtask

    initial begin
        int held;
        int got;
        int seed_val;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) mdl[i][j] = 0;
        seed_val = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !wr_reject && energy == 0, "R1 reset outputs",
              int'(busy) + int'(done) + int'(wr_reject), 0);
        eval_chk('1, "R1 coefficients cleared");

        // R2 diagonal and pair terms
        write_coef(2, 2, 5, 1'b0);
        eval_chk(8'b0000_0100, "R2 diagonal term");
        eval_chk(8'b0000_0001, "R2 unset variable");
        write_coef(0, 2, -3, 1'b0);
        eval_chk(8'b0000_0101, "R2 pair term");
        eval_chk(8'b0000_0001, "R2 pair needs both bits");

        // R3 lower-triangle write folds
        write_coef(5, 1, -7, 1'b0);
        eval_chk(8'b0010_0010, "R3 folded write");
        // R9 overwrite
        write_coef(1, 5, 9, 1'b0);
        eval_chk(8'b0010_0010, "R9 overwrite");

        // R5 result holds while idle
        held = int'(energy);
        repeat (6) @(negedge clk);
        check(done && int'(energy) == held, "R5 result held", int'(energy), held);

        // R6 and R7: write and second start during busy
        @(negedge clk);
        start = 1'b1; cand = 8'b0010_0110;
        @(negedge clk);
        start = 1'b1; cand = 8'b0000_0001;
        wr_en = 1'b1; wr_row = 3'd2; wr_col = 3'd2; wr_coef = 8'd99;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        check(wr_reject == 1'b1, "R7 reject pulse", int'(wr_reject), 1);
        @(negedge clk);
        check(wr_reject == 1'b0, "R7 reject one cycle", int'(wr_reject), 0);
        wait_done();
        got = int'(energy);
        check(got == ref_energy(8'b0010_0110), "R6 second start ignored", got, ref_energy(8'b0010_0110));
        eval_chk(8'b0000_0100, "R7 coefficient unchanged");

        // R8 write together with start
        @(negedge clk);
        wr_en = 1'b1; wr_row = 3'd3; wr_col = 3'd3; wr_coef = CW'(-20);
        start = 1'b1; cand = 8'b0000_1100;
        @(negedge clk);
        wr_en = 1'b0; start = 1'b0;
        mdl[3][3] = -20;
        wait_done();
        got = int'(energy);
        check(got == ref_energy(8'b0000_1100), "R8 same-cycle write used", got, ref_energy(8'b0000_1100));

        // R10 extremes
        for (int i = 0; i < N; i++)
            for (int j = i; j < N; j++) write_coef(i, j, 127, 1'b0);
        eval_chk('1, "R10 all maximum");
        for (int i = 0; i < N; i++)
            for (int j = i; j < N; j++) write_coef(j, i, -128, 1'b0);
        eval_chk('1, "R10 all minimum");

        // R2 random mix
        for (int t = 0; t < 150; t++) begin
            int nw;
            nw = int'($urandom_range(0, 4));
            for (int w = 0; w < nw; w++)
                write_coef(int'($urandom_range(0, N - 1)), int'($urandom_range(0, N - 1)),
                           int'($urandom_range(0, 255)) - 128, 1'b0);
            eval_chk(N'($urandom), "R2 random evaluation");
        end

        report();
    end

endmodule